// File: doc/BRIEF.md
# Dual-Channel Snapshot Capture Controller

This block takes one fixed-length block of samples from one or two converter channels and holds it in on-chip buffers. It then returns the block over a single shared 16-bit read bus. A start command from the host side clears both buffers. While acquisition runs, the block holds a quiet request so that the host-side interface can go idle.

Each channel fills its own buffer on its own sample clock. A per-channel configuration bit can invert that clock, so that data is taken on the opposite edge. A buffer stops accepting data once it is full. The full flags are brought into the host clock through two-flop synchronizers. When every selected buffer is full, the block raises a wake pulse. It then waits a host-programmable settle delay and streams the stored words out.

In single-channel mode only buffer A is returned. In dual mode buffer A is returned first and buffer B second. Two output enables, never both active, show which buffer drives the bus. A done pulse closes the readback. Start commands that arrive while a run is in progress are dropped.

Top module: `snap_capture_ctrl`

## Requirements
- R1: After reset, busy, quiet, wake, both output enables, read-valid and done are all 0, and the read bus is 0.
- R2: Busy goes high the cycle after an accepted start. Quiet is high during acquisition, is low at the wake pulse, and is never high while a word is being read.
- R3: Both buffers are cleared before any new sample is written. Every stored word was taken after the start command.
- R4: A buffer holds exactly DEPTH words, taken on consecutive sample-clock edges. Writing stops at full, so no word is overwritten.
- R5: Wake is a single-cycle pulse. In dual mode it is raised only after both synchronized full flags are set. In single mode it depends on buffer A alone.
- R6: The first read word appears exactly settle_i + 1 host cycles after the wake pulse.
- R7: At most one output enable is high at any time. Read-valid implies exactly one enable. The bus reads 0 when neither enable is high.
- R8: Single mode returns DEPTH words from A only. Dual mode returns DEPTH words from A and then DEPTH words from B, and never returns to A.
- R9: Done is a one-cycle pulse in the cycle right after the last word. Busy is low in that same cycle.
- R10: A start command during acquisition, settling or readback has no effect: no restart, no extra words, and busy stays low after the single done.
- R11: With the invert bit 0 a channel captures on the rising edge of its sample clock. With the invert bit 1 it captures on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-capture command, one host cycle |
| dual_i | input | 1 | 1 = dual/demultiplexed mode, 0 = single (channel A) |
| settle_i | input | SET_W | Settle delay in host cycles between wake and readback |
| inv_a_i | input | 1 | Invert channel A sample clock |
| inv_b_i | input | 1 | Invert channel B sample clock |
| sclk_a_i | input | 1 | Channel A sample clock |
| sclk_b_i | input | 1 | Channel B sample clock |
| din_a_i | input | DW | Channel A sample data |
| din_b_i | input | DW | Channel B sample data |
| busy_o | output | 1 | Capture or readback in progress |
| quiet_o | output | 1 | Request for the host side to idle during acquisition |
| wake_o | output | 1 | Single-cycle pulse when the selected buffers are full |
| oe_a_o | output | 1 | Buffer A drives the read bus |
| oe_b_o | output | 1 | Buffer B drives the read bus |
| rd_valid_o | output | 1 | Read bus carries a stored word |
| rd_data_o | output | DW | Shared read bus |
| rd_done_o | output | 1 | Pulse after the last returned word |

## Verification
The bench holds channel B's clock stopped while A fills. A design that treated either full flag as enough would wake early and return a half-empty buffer B. Each channel's data switches a marker bit between the two clock phases, so a capture on the wrong edge shows up as the wrong marker. A buffer that wrapped past full shows up as a break in the counter sequence, and a buffer that kept stale words shows up as counts older than the start. The bench sends start commands during acquisition and during readback. A design that honoured them would restart, return extra words or stay busy. It also measures the exact wake-to-first-word gap, so an off-by-one settle counter is caught.

// File: rtl/snap_pkg.sv
`timescale 1ns/1ps
package snap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ACQ,
        ST_SETTLE,
        ST_READ
    } snap_state_e;
endpackage

// File: rtl/snap_flag_sync.sv
`timescale 1ns/1ps
module snap_flag_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic flag_i,
    output logic flag_o
);
    logic [1:0] stage_q;
    logic [1:0] stage_d;

    always_comb begin
        stage_d = {stage_q[0], flag_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= stage_d;
    end

    assign flag_o = stage_q[1];
endmodule

// File: rtl/snap_chan_buf.sv
`timescale 1ns/1ps
module snap_chan_buf #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          rst_ni,
    input  logic          sclk_i,
    input  logic          inv_i,
    input  logic [DW-1:0] din_i,
    input  logic          clr_i,
    output logic          full_o,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);
    typedef struct packed {
        logic          clr_s1;
        logic          clr_s2;
        logic [AW-1:0] wptr;
        logic          full;
    } wr_t;

    wr_t           wr_q, wr_d;
    logic          we;
    logic          wclk;
    logic [DW-1:0] mem [DEPTH];

    assign wclk = sclk_i ^ inv_i;

    always_comb begin
        wr_d        = wr_q;
        wr_d.clr_s1 = clr_i;
        wr_d.clr_s2 = wr_q.clr_s1;
        we          = 1'b0;
        if (wr_q.clr_s2) begin
            wr_d.wptr = '0;
            wr_d.full = 1'b0;
        end else if (!wr_q.full) begin
            we        = 1'b1;
            wr_d.wptr = wr_q.wptr + 1'b1;
            wr_d.full = (wr_q.wptr == AW'(DEPTH - 1));
        end
    end

    always_ff @(posedge wclk or negedge rst_ni) begin
        if (!rst_ni) wr_q <= '0;
        else         wr_q <= wr_d;
    end

    always_ff @(posedge wclk) begin
        if (we) mem[wr_q.wptr] <= din_i;
    end

    assign full_o    = wr_q.full;
    assign rd_data_o = mem[rd_addr_i];

    // R4
    wptr_frozen_chk: assert property (@(posedge wclk) disable iff (!rst_ni)
        (wr_q.full && !wr_q.clr_s2) |=> (wr_q.wptr == $past(wr_q.wptr)));
endmodule

// File: rtl/snap_seq.sv
`timescale 1ns/1ps
module snap_seq
    import snap_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int SET_W   = 24,
    parameter int CLR_CYC = 8,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             dual_i,
    input  logic [SET_W-1:0] settle_i,
    input  logic             full_a_i,
    input  logic             full_b_i,
    output logic             clr_o,
    output logic             quiet_o,
    output logic             wake_o,
    output logic             busy_o,
    output logic             oe_a_o,
    output logic             oe_b_o,
    output logic             valid_o,
    output logic             done_o,
    output logic [AW-1:0]    addr_o
);
    typedef struct packed {
        snap_state_e      state;
        logic [SET_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic             dual;
        logic             clr;
        logic             quiet;
        logic             wake;
        logic             oe_a;
        logic             oe_b;
        logic             valid;
        logic             done;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        d.wake = 1'b0;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: if (start_i) begin
                d.state = ST_CLEAR;
                d.cnt   = '0;
                d.dual  = dual_i;
                d.clr   = 1'b1;
            end
            ST_CLEAR: if (q.cnt == SET_W'(CLR_CYC - 1)) begin
                d.state = ST_ACQ;
                d.clr   = 1'b0;
                d.quiet = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
            ST_ACQ: if (full_a_i && (full_b_i || !q.dual)) begin
                d.state = ST_SETTLE;
                d.quiet = 1'b0;
                d.wake  = 1'b1;
                d.cnt   = '0;
            end
            ST_SETTLE: if (q.cnt == settle_i) begin
                d.state = ST_READ;
                d.addr  = '0;
                d.oe_a  = 1'b1;
                d.valid = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
            ST_READ: if (q.addr == AW'(DEPTH - 1)) begin
                if (q.oe_a && q.dual) begin
                    d.oe_a = 1'b0;
                    d.oe_b = 1'b1;
                    d.addr = '0;
                end else begin
                    d.state = ST_IDLE;
                    d.oe_a  = 1'b0;
                    d.oe_b  = 1'b0;
                    d.valid = 1'b0;
                    d.done  = 1'b1;
                end
            end else begin
                d.addr = q.addr + 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{state: ST_IDLE, default: '0};
        else         q <= d;
    end

    assign clr_o   = q.clr;
    assign quiet_o = q.quiet;
    assign wake_o  = q.wake;
    assign busy_o  = (q.state != ST_IDLE);
    assign oe_a_o  = q.oe_a;
    assign oe_b_o  = q.oe_b;
    assign valid_o = q.valid;
    assign done_o  = q.done;
    assign addr_o  = q.addr;

    // R7
    oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(q.oe_a && q.oe_b));
    // R5
    wake_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.wake |-> ($past(full_a_i) && ($past(full_b_i) || !q.dual)));
    // R9
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |=> !q.done);
    // R10
    no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_ACQ || q.state == ST_SETTLE || q.state == ST_READ)
            |=> (q.state != ST_CLEAR));
    // R2
    quiet_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.quiet |-> (!q.valid && !q.oe_a && !q.oe_b));
endmodule

// File: rtl/snap_capture_ctrl.sv
`timescale 1ns/1ps
module snap_capture_ctrl #(
    parameter int DW      = 16,
    parameter int DEPTH   = 64,
    parameter int SET_W   = 24,
    parameter int CLR_CYC = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             dual_i,
    input  logic [SET_W-1:0] settle_i,
    input  logic             inv_a_i,
    input  logic             inv_b_i,
    input  logic             sclk_a_i,
    input  logic             sclk_b_i,
    input  logic [DW-1:0]    din_a_i,
    input  logic [DW-1:0]    din_b_i,
    output logic             busy_o,
    output logic             quiet_o,
    output logic             wake_o,
    output logic             oe_a_o,
    output logic             oe_b_o,
    output logic             rd_valid_o,
    output logic [DW-1:0]    rd_data_o,
    output logic             rd_done_o
);
    localparam int NCH = 2;
    localparam int AW  = $clog2(DEPTH);

    logic          sclk_v [NCH];
    logic          inv_v  [NCH];
    logic [DW-1:0] din_v  [NCH];
    logic [DW-1:0] rdat_v [NCH];
    logic          full_raw [NCH];
    logic          full_syn [NCH];
    logic          clr;
    logic [AW-1:0] addr;

    assign sclk_v[0] = sclk_a_i;
    assign sclk_v[1] = sclk_b_i;
    assign inv_v[0]  = inv_a_i;
    assign inv_v[1]  = inv_b_i;
    assign din_v[0]  = din_a_i;
    assign din_v[1]  = din_b_i;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        snap_chan_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
            .rst_ni    (rst_ni),
            .sclk_i    (sclk_v[c]),
            .inv_i     (inv_v[c]),
            .din_i     (din_v[c]),
            .clr_i     (clr),
            .full_o    (full_raw[c]),
            .rd_addr_i (addr),
            .rd_data_o (rdat_v[c])
        );
        snap_flag_sync u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .flag_i (full_raw[c]),
            .flag_o (full_syn[c])
        );
    end

    snap_seq #(.DEPTH(DEPTH), .SET_W(SET_W), .CLR_CYC(CLR_CYC)) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .dual_i   (dual_i),
        .settle_i (settle_i),
        .full_a_i (full_syn[0]),
        .full_b_i (full_syn[1]),
        .clr_o    (clr),
        .quiet_o  (quiet_o),
        .wake_o   (wake_o),
        .busy_o   (busy_o),
        .oe_a_o   (oe_a_o),
        .oe_b_o   (oe_b_o),
        .valid_o  (rd_valid_o),
        .done_o   (rd_done_o),
        .addr_o   (addr)
    );

    always_comb begin
        rd_data_o = '0;
        if (oe_a_o)      rd_data_o = rdat_v[0];
        else if (oe_b_o) rd_data_o = rdat_v[1];
    end
endmodule

// File: tb/tb_snap_capture_ctrl.sv
`timescale 1ns/1ps
module tb_snap_capture_ctrl;
    localparam int DW = 16, DEPTH = 64, SET_W = 24, CLR_CYC = 8;

    logic clk = 0, rst_n = 0, start = 0, dual = 0, inv_a = 0, inv_b = 0;
    logic sclk_a = 0, sclk_b_raw = 0, en_b = 0;
    logic sclk_b;
    logic [SET_W-1:0] settle = '0;
    logic [DW-1:0] da = 16'h8000, db = 16'h8000;
    logic [14:0] cnt_a = '0, cnt_b = '0;
    logic busy, quiet, wake, oe_a, oe_b, valid, done;
    logic [DW-1:0] rdata;
    int checks = 0, errors = 0;

    assign sclk_b = sclk_b_raw & en_b;

    always #5   clk = ~clk;
    always #3.5 sclk_a = ~sclk_a;
    always #4.5 sclk_b_raw = ~sclk_b_raw;

    always @(posedge sclk_a) begin #1; cnt_a = cnt_a + 1'b1; da = {1'b0, cnt_a}; end
    always @(negedge sclk_a) begin #1; da = {1'b1, cnt_a}; end
    always @(posedge sclk_b) begin #1; cnt_b = cnt_b + 1'b1; db = {1'b0, cnt_b}; end
    always @(negedge sclk_b) begin #1; db = {1'b1, cnt_b}; end

    snap_capture_ctrl #(.DW(DW), .DEPTH(DEPTH), .SET_W(SET_W), .CLR_CYC(CLR_CYC)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dual_i(dual), .settle_i(settle),
        .inv_a_i(inv_a), .inv_b_i(inv_b), .sclk_a_i(sclk_a), .sclk_b_i(sclk_b),
        .din_a_i(da), .din_b_i(db), .busy_o(busy), .quiet_o(quiet), .wake_o(wake),
        .oe_a_o(oe_a), .oe_b_o(oe_b), .rd_valid_o(valid), .rd_data_o(rdata),
        .rd_done_o(done)
    );

    function automatic logic exp_marker(input logic inv);
        return ~inv;
    endfunction
    function automatic logic [14:0] exp_next(input logic [14:0] w);
        return w + 1'b1;
    endfunction
    function automatic int exp_gap(input int st);
        return st + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_words(input logic [DW-1:0] w [DEPTH], input logic inv,
                               input logic [14:0] s0, input bit win);
        logic [14:0] delta;
        delta = w[0][14:0] - s0;
        // R3: first stored word taken after the start command
        if (win) chk(delta >= 1 && delta <= 40, "R3", int'(delta), 14);
        for (int i = 0; i < DEPTH; i++) begin
            // R11: marker bit shows which clock edge captured the word
            chk(w[i][15] == exp_marker(inv), "R11", int'(w[i][15]), int'(exp_marker(inv)));
            // R4: consecutive samples, no overwrite after full
            if (i > 0)
                chk(w[i][14:0] == exp_next(w[i-1][14:0]), "R4",
                    int'(w[i][14:0]), int'(exp_next(w[i-1][14:0])));
        end
    endtask

    task automatic run_capture(input bit dl, input bit ia, input bit ib, input int st,
                               input bit hold_b, input bit pest);
        logic [DW-1:0] wa [DEPTH];
        logic [DW-1:0] wb [DEPTH];
        logic [14:0] sa, sb;
        int na, nb, gap, tmo, wk;
        bit b_seen;
        @(negedge clk);
        dual = dl; inv_a = ia; inv_b = ib; settle = SET_W'(st);
        repeat (4) @(negedge clk);
        sa = cnt_a; sb = cnt_b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", int'(busy), 1);
        repeat (CLR_CYC + 3) @(negedge clk);
        chk(quiet == 1'b1, "R2", int'(quiet), 1);
        if (pest) begin
            start = 1'b1;  // R10: start during acquisition
            @(negedge clk);
            start = 1'b0;
        end
        if (hold_b) begin
            wk = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (wake) wk++;
            end
            // R5: no wake while channel B is still empty
            chk(wk == 0, "R5", wk, 0);
            chk(quiet == 1'b1, "R5", int'(quiet), 1);
            en_b = 1'b1;
        end
        tmo = 0;
        while (!wake && tmo < 3000) begin @(negedge clk); tmo++; end
        chk(wake == 1'b1, "R5", int'(wake), 1);
        chk(quiet == 1'b0, "R2", int'(quiet), 0);
        @(negedge clk);
        // R5: wake lasts one cycle
        chk(wake == 1'b0, "R5", int'(wake), 0);
        gap = 1;
        while (!valid && gap < st + 10) begin @(negedge clk); gap++; end
        // R6
        chk(gap == exp_gap(st), "R6", gap, exp_gap(st));
        na = 0; nb = 0; b_seen = 0;
        while (valid) begin
            // R7
            chk((oe_a ^ oe_b) == 1'b1, "R7", int'({oe_a, oe_b}), 2);
            chk(done == 1'b0, "R9", int'(done), 0);
            if (oe_a) begin
                chk(!b_seen, "R8", int'(b_seen), 0);
                if (na < DEPTH) wa[na] = rdata;
                na++;
            end
            if (oe_b) begin
                b_seen = 1'b1;
                if (nb < DEPTH) wb[nb] = rdata;
                nb++;
            end
            if (pest && na + nb == 10) start = 1'b1;  // R10: start during readback
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        // R9
        chk(done == 1'b1, "R9", int'(done), 1);
        chk(busy == 1'b0, "R9", int'(busy), 0);
        // R7: bus idle value
        chk(rdata == '0, "R7", int'(rdata), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9", int'(done), 0);
        // R8
        chk(na == DEPTH, "R8", na, DEPTH);
        chk(nb == (dl ? DEPTH : 0), "R8", nb, dl ? DEPTH : 0);
        if (na == DEPTH) check_words(wa, ia, sa, 1'b1);
        if (dl && nb == DEPTH) check_words(wb, ib, sb, !hold_b);
        if (pest) begin
            wk = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (busy || valid) wk++;
            end
            // R10: ignored starts did not queue a new run
            chk(wk == 0, "R10", wk, 0);
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk({busy, quiet, wake, oe_a, oe_b, valid, done} == 7'b0, "R1",
            int'({busy, quiet, wake, oe_a, oe_b, valid, done}), 0);
        chk(rdata == '0, "R1", int'(rdata), 0);
        run_capture(1'b1, 1'b0, 1'b0, 3, 1'b1, 1'b0);
        run_capture(1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        run_capture(1'b1, 1'b1, 1'b1, 5, 1'b0, 1'b1);
        for (int r = 0; r < 6; r++) begin
            run_capture(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                        int'($urandom % 20), 1'b0, 1'b0);
        end
        run_capture(1'b0, 1'b0, 1'b1, 2, 1'b0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule